// File: doc/BRIEF.md
# Indirect Auto-Advancing Register Port

This block gives a host processor access to a bank of 26 byte-wide control registers through only two byte-wide host locations. The first location is the address port, selected with `host_addr_sel` high. A write to it chooses a register index, and a read from it returns a live auxiliary status byte. The second location is the value port, selected with `host_addr_sel` low. It reads or writes whichever register the index currently points at. After each value access that is carried out, the index moves on by one. Software can therefore load or read a multi-byte field after writing the starting index once. Typical fields are the three-byte transfer count, stored most-significant byte first at indices 18 to 20, and a command descriptor of up to twelve bytes starting at index 3.

The protocol engine behind the registers is outside this block. It reports its state on a few level inputs: busy, command in progress, parity error and data-buffer-ready. It raises an interrupt with a one-cycle strobe, and that strobe also loads a cause byte into the status register (index 23). While the engine is busy, only the command register (24) and the data register (25) can be reached through the value port. While a command is in progress, the command register is also closed to the value port. A command write that is accepted is handed to the engine as a one-cycle start pulse. A command write attempted during command-in-progress is dropped and flagged.

Host strobes are sampled on the rising clock edge. Read data is registered and appears on `host_rdata` in the cycle after the read strobe. If `host_wr` and `host_rd` are both high, the write is taken and the read is ignored.

Top module: `indirect_reg_port`

## Requirements
- R1: A host write to the address port loads the register index from `host_wdata[4:0]`. A host read of the address port returns the auxiliary status byte, not the index, on `host_rdata` one cycle after the strobe.
- R2: The auxiliary status byte has the following layout:
  - bit 7: interrupt pending
  - bit 6: last command ignored
  - bit 5: `eng_busy`
  - bit 4: `eng_cip`
  - bits 3 and 2: zero
  - bit 1: `eng_perr`
  - bit 0: `eng_dbr`
- R3: Each value-port access that is carried out at an index below 25 increments the index by one. At index 25 (data) the index holds, so repeated accesses stream through the data register.
- R4: After a single index write of 18, three value writes fill indices 18, 19 and 20. `xfer_count` equals {reg18, reg19, reg20}, most-significant byte first, and the same bytes read back in the same order.
- R5: After a single index write, every register from that index up to 25 can be written or read back-to-back through the value port. This includes a command descriptor of up to 12 bytes at indices 3 to 14.
- R6: While `eng_busy` is high and `eng_cip` is low, value accesses at indices other than 24 and 25 are refused. A refused read returns 0x00, a refused write changes nothing, and the index does not advance. Indices 24 and 25 remain accessible.
- R7: While `eng_cip` is high, the command register is refused as well. A command write is discarded, gives no start pulse, and sets the last-command-ignored bit. A command read returns 0x00.
- R8: An accepted command write stores the byte, pulses `cmd_start` for one cycle in the next cycle with `cmd_code` equal to the byte, and clears the last-command-ignored bit.
- R9: An `eng_int_set` strobe sets interrupt pending and loads `eng_status` into register 23. An accepted value read of index 23 clears interrupt pending. If a set and a clear fall in the same cycle, the set wins.
- R10: At an index from 26 to 31, value reads return 0x00 and value writes change no register.
- R11: Reset (synchronous, `rst_n` low) clears the index, all 26 registers, both sticky status bits, `host_rdata` and `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr_sel | input | 1 | 1 selects the address/status port, 0 selects the value port |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| eng_busy | input | 1 | Engine busy level |
| eng_cip | input | 1 | Engine command-in-progress level |
| eng_perr | input | 1 | Engine parity error level |
| eng_dbr | input | 1 | Engine data-buffer-ready level |
| eng_int_set | input | 1 | Engine interrupt strobe; loads `eng_status` into register 23 |
| eng_status | input | 8 | Interrupt cause byte |
| cmd_start | output | 1 | One-cycle pulse after an accepted command write |
| cmd_code | output | 8 | Contents of the command register |
| xfer_count | output | 24 | Transfer count {reg18, reg19, reg20} |

## Verification
A wrong index value shows up at the very next value read as a byte from the wrong register. A lost or doubled step shows up one access later as a shifted stream. This is why the bench streams every register out of a single index write and loads every index from 0 to 31 directly. A gating fault is visible in the first cycle after a refused access: either a nonzero read, or a changed byte found once the engine goes idle. The sticky interrupt and ignored-command bits, and a missing or spurious `cmd_start`, are visible in the cycle right after the access that should change them.

// File: rtl/irp_pkg.sv
// Package: shared constants for the indirect register port.
// Assumes an 8-bit host data path; the bit positions of the auxiliary
// status byte are fixed here because host software decodes them.
package irp_pkg;
    localparam int unsigned ASR_INT  = 7;
    localparam int unsigned ASR_LCI  = 6;
    localparam int unsigned ASR_BSY  = 5;
    localparam int unsigned ASR_CIP  = 4;
    localparam int unsigned ASR_PERR = 1;
    localparam int unsigned ASR_DBR  = 0;

    // Decoded host operation for one clock cycle.
    typedef struct packed {
        logic addr_wr;
        logic addr_rd;
        logic val_wr;
        logic val_rd;
    } host_op_t;
endpackage

// File: rtl/irp_index_ptr.sv
// Module: register index pointer.
// Loads a new index from the address port and steps by one after each
// granted value access, saturating at LAST_IDX. Assumes load and step
// are never high together (address and value port are exclusive).
module irp_index_ptr #(
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned LAST_IDX = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

    logic [IDX_W-1:0] idx_q;

    // Index register: load wins, otherwise step until the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= load_val;
        end else if (step && (idx_q < LAST)) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/irp_access_gate.sv
// Module: access rules for value-port accesses.
// Decides whether a value access at the current index is carried out,
// given the engine's busy and command-in-progress levels. Assumes the
// caller has already separated value reads from value writes.
module irp_access_gate #(
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned NUM_REGS = 26,
    parameter int unsigned CMD_IDX  = 24,
    parameter int unsigned DATA_IDX = 25
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             busy,
    input  logic             cip,
    input  logic             val_wr,
    input  logic             val_rd,
    output logic             grant,
    output logic             cmd_ignored
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] CMD     = IDX_W'(CMD_IDX);
    localparam logic [IDX_W-1:0] DATA    = IDX_W'(DATA_IDX);

    logic in_range;
    logic allowed;

    // Per-index permission under the current engine state.
    always_comb begin
        in_range = (idx <= TOP_IDX);
        if (cip) begin
            allowed = (idx == DATA);
        end else if (busy) begin
            allowed = (idx == DATA) || (idx == CMD);
        end else begin
            allowed = 1'b1;
        end
        grant       = (val_wr || val_rd) && in_range && allowed;
        cmd_ignored = val_wr && cip && (idx == CMD);
    end
endmodule

// File: rtl/irp_reg_bank.sv
// Module: byte register bank.
// One host write port and a combinational read mux. The status entry
// can also be loaded by the engine, which has priority over the host.
// The transfer count bytes and the command byte are brought out directly.
module irp_reg_bank #(
    parameter int unsigned NUM_REGS   = 26,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned STATUS_IDX = 23,
    parameter int unsigned CMD_IDX    = 24,
    parameter int unsigned CNT_IDX    = 18,
    parameter int unsigned CNT_BYTES  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          eng_load,
    input  logic [DATA_W-1:0]             eng_data,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W-1:0]             cmd_out,
    output logic [CNT_BYTES*DATA_W-1:0]   cnt_out
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == STATUS_IDX) begin : g_status
            // Status byte: engine load first, then host write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (eng_load) begin
                    regs[g] <= eng_data;
                end else if (wr_en && (idx == IDX_W'(g))) begin
                    regs[g] <= wr_data;
                end
            end
        end else begin : g_plain
            // Plain host-written byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (wr_en && (idx == IDX_W'(g))) begin
                    regs[g] <= wr_data;
                end
            end
        end
    end

    // Read mux over the bank; out-of-range indices read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

    // Count field, lowest index is the most-significant byte.
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
        assign cnt_out[(CNT_BYTES-1-b)*DATA_W +: DATA_W] = regs[CNT_IDX+b];
    end

    assign cmd_out = regs[CMD_IDX];
endmodule

// File: rtl/irp_aux_flags.sv
// Module: sticky auxiliary status flags.
// Holds interrupt pending and last-command-ignored. Set has priority
// over clear for both flags.
module irp_aux_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic int_set,
    input  logic int_clr,
    input  logic lci_set,
    input  logic lci_clr,
    output logic int_pend,
    output logic lci
);
    // Interrupt pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend <= 1'b0;
        end else if (int_set) begin
            int_pend <= 1'b1;
        end else if (int_clr) begin
            int_pend <= 1'b0;
        end
    end

    // Last-command-ignored flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lci <= 1'b0;
        end else if (lci_set) begin
            lci <= 1'b1;
        end else if (lci_clr) begin
            lci <= 1'b0;
        end
    end
endmodule

// File: rtl/indirect_reg_port.sv
// Module: indirect auto-advancing register port (top).
// Two host locations give access to a register bank through an index
// pointer. Assumes one-cycle host strobes; on a simultaneous read and
// write the write is taken. Read data is registered.
module indirect_reg_port #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_REGS   = 26,
    parameter int unsigned STATUS_IDX = 23,
    parameter int unsigned CMD_IDX    = 24,
    parameter int unsigned DATA_IDX   = 25,
    parameter int unsigned CNT_IDX    = 18,
    parameter int unsigned CNT_BYTES  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_addr_sel,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic [DATA_W-1:0]           host_rdata,
    input  logic                        eng_busy,
    input  logic                        eng_cip,
    input  logic                        eng_perr,
    input  logic                        eng_dbr,
    input  logic                        eng_int_set,
    input  logic [DATA_W-1:0]           eng_status,
    output logic                        cmd_start,
    output logic [DATA_W-1:0]           cmd_code,
    output logic [CNT_BYTES*DATA_W-1:0] xfer_count
);
    import irp_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam logic [IDX_W-1:0] STATUS = IDX_W'(STATUS_IDX);
    localparam logic [IDX_W-1:0] CMD    = IDX_W'(CMD_IDX);

    host_op_t          op;
    logic [IDX_W-1:0]  idx_q;
    logic              grant;
    logic              cmd_ignored;
    logic [DATA_W-1:0] bank_rd;
    logic              int_q;
    logic              lci_q;
    logic              cmd_accept;
    logic [DATA_W-1:0] asr;
    logic              cmd_start_q;
    logic [DATA_W-1:0] rdata_q;

    // Decode the host strobes into one operation.
    always_comb begin
        op.addr_wr = host_wr && host_addr_sel;
        op.val_wr  = host_wr && !host_addr_sel;
        op.addr_rd = host_rd && !host_wr && host_addr_sel;
        op.val_rd  = host_rd && !host_wr && !host_addr_sel;
    end

    irp_index_ptr #(
        .IDX_W    (IDX_W),
        .LAST_IDX (DATA_IDX)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (op.addr_wr),
        .load_val (host_wdata[IDX_W-1:0]),
        .step     (grant),
        .idx      (idx_q)
    );

    irp_access_gate #(
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS),
        .CMD_IDX  (CMD_IDX),
        .DATA_IDX (DATA_IDX)
    ) u_gate (
        .idx         (idx_q),
        .busy        (eng_busy),
        .cip         (eng_cip),
        .val_wr      (op.val_wr),
        .val_rd      (op.val_rd),
        .grant       (grant),
        .cmd_ignored (cmd_ignored)
    );

    irp_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .STATUS_IDX (STATUS_IDX),
        .CMD_IDX    (CMD_IDX),
        .CNT_IDX    (CNT_IDX),
        .CNT_BYTES  (CNT_BYTES)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (op.val_wr && grant),
        .idx      (idx_q),
        .wr_data  (host_wdata),
        .eng_load (eng_int_set),
        .eng_data (eng_status),
        .rd_data  (bank_rd),
        .cmd_out  (cmd_code),
        .cnt_out  (xfer_count)
    );

    assign cmd_accept = op.val_wr && grant && (idx_q == CMD);

    irp_aux_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_set  (eng_int_set),
        .int_clr  (op.val_rd && grant && (idx_q == STATUS)),
        .lci_set  (cmd_ignored),
        .lci_clr  (cmd_accept),
        .int_pend (int_q),
        .lci      (lci_q)
    );

    // Assemble the live auxiliary status byte.
    always_comb begin
        asr           = '0;
        asr[ASR_INT]  = int_q;
        asr[ASR_LCI]  = lci_q;
        asr[ASR_BSY]  = eng_busy;
        asr[ASR_CIP]  = eng_cip;
        asr[ASR_PERR] = eng_perr;
        asr[ASR_DBR]  = eng_dbr;
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (op.addr_rd) begin
            rdata_q <= asr;
        end else if (op.val_rd) begin
            rdata_q <= grant ? bank_rd : '0;
        end
    end

    // One-cycle start pulse after an accepted command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start_q <= 1'b0;
        end else begin
            cmd_start_q <= cmd_accept;
        end
    end

    assign host_rdata = rdata_q;
    assign cmd_start  = cmd_start_q;
endmodule

// File: rtl/irp_checker.sv
// Module: temporal checks on the indirect register port, bound to the top.
// Observes ports plus the index and sticky flags.
module irp_checker #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned STATUS_IDX = 23,
    parameter int unsigned CMD_IDX    = 24,
    parameter int unsigned DATA_IDX   = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_addr_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              eng_busy,
    input logic              eng_cip,
    input logic              eng_int_set,
    input logic              cmd_start,
    input logic [IDX_W-1:0]  idx_q,
    input logic              int_q,
    input logic              lci_q
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic val_wr, val_rd, addr_rd;
    assign val_wr  = host_wr && !host_addr_sel;
    assign val_rd  = host_rd && !host_wr && !host_addr_sel;
    assign addr_rd = host_rd && !host_wr && host_addr_sel;

    assert_asr_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rd |=> (host_rdata[3:2] == 2'b00) && (host_rdata[5] == $past(eng_busy))
                    && (host_rdata[4] == $past(eng_cip)));

    assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr || val_rd) |=> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + ONE));

    assert_index_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((val_wr || val_rd) && (idx_q >= IDX_W'(DATA_IDX))) |=> $stable(idx_q));

    assert_busy_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (val_rd && eng_busy && (idx_q < IDX_W'(CMD_IDX))) |=> (host_rdata == '0));

    assert_cip_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && eng_cip && (idx_q == IDX_W'(CMD_IDX))) |=> (lci_q && !cmd_start));

    assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(val_wr && !eng_cip && (idx_q == IDX_W'(CMD_IDX))));

    assert_int_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (val_rd && !eng_busy && !eng_cip && !eng_int_set && (idx_q == IDX_W'(STATUS_IDX)))
        |=> !int_q);

    assert_range_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (val_rd && (idx_q > IDX_W'(DATA_IDX))) |=> (host_rdata == '0));
endmodule

bind indirect_reg_port irp_checker #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .STATUS_IDX (STATUS_IDX),
    .CMD_IDX    (CMD_IDX),
    .DATA_IDX   (DATA_IDX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr_sel (host_addr_sel),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_rdata    (host_rdata),
    .eng_busy      (eng_busy),
    .eng_cip       (eng_cip),
    .eng_int_set   (eng_int_set),
    .cmd_start     (cmd_start),
    .idx_q         (idx_q),
    .int_q         (int_q),
    .lci_q         (lci_q)
);

// File: tb/tb_indirect_reg_port.sv
// Bench: sweeps over all indices and engine states with a bench-side
// model of the register contents.
module tb_indirect_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        eng_busy = 1'b0;
    logic        eng_cip = 1'b0;
    logic        eng_perr = 1'b0;
    logic        eng_dbr = 1'b0;
    logic        eng_int_set = 1'b0;
    logic [7:0]  eng_status = '0;
    logic        cmd_start;
    logic [7:0]  cmd_code;
    logic [23:0] xfer_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [26];

    always #4 clk = ~clk;

    indirect_reg_port dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic sel, input logic wr, input logic [7:0] v);
        @(negedge clk);
        host_addr_sel = sel;
        host_wr = wr;
        host_rd = !wr;
        host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
    endtask

    task automatic addr_wr(input logic [7:0] v); strobe(1'b1, 1'b1, v); endtask
    task automatic val_wr(input logic [7:0] v);  strobe(1'b0, 1'b1, v); endtask
    task automatic val_rd(output logic [7:0] d); strobe(1'b0, 1'b0, 8'h00); d = host_rdata; endtask
    task automatic asr_rd(output logic [7:0] d); strobe(1'b1, 1'b0, 8'h00); d = host_rdata; endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        asr_rd(d); chk("R11 asr after reset", d, 8'h00);
        chk("R11 cmd_start after reset", cmd_start, 1'b0);
        chk("R11 count after reset", xfer_count, 24'h0);
        addr_wr(8'd0);
        for (int i = 0; i < 26; i++) begin
            val_rd(d); chk("R11 register after reset", d, 8'h00);
        end

        // R2: status layout over every engine level combination
        for (int c = 0; c < 16; c++) begin
            eng_busy = c[3]; eng_cip = c[2]; eng_perr = c[1]; eng_dbr = c[0];
            asr_rd(d);
            chk("R2 asr layout", d, {2'b00, c[3], c[2], 2'b00, c[1], c[0]});
        end
        eng_busy = 0; eng_cip = 0; eng_perr = 0; eng_dbr = 0;

        // R5 R3: stream all registers after one index write, then read back
        addr_wr(8'd0);
        for (int i = 0; i < 26; i++) begin
            model[i] = 8'((i * 37 + 5) & 8'hFF);
            val_wr(model[i]);
        end
        addr_wr(8'd0);
        for (int i = 0; i < 26; i++) begin
            val_rd(d); chk("R5 streamed readback", d, model[i]);
        end
        val_rd(d); chk("R3 index holds at data register", d, model[25]);

        // R1 R10: direct load of every index value; high bits of byte ignored
        for (int i = 0; i < 32; i++) begin
            addr_wr(8'(i | 8'hE0));
            val_rd(d); chk("R1 R10 direct index read", d, (i < 26) ? model[i] : 8'h00);
        end

        // R10: writes beyond the bank change nothing
        addr_wr(8'd28); val_wr(8'h55); val_wr(8'h66);
        addr_wr(8'd0);
        for (int i = 0; i < 26; i++) begin
            val_rd(d); chk("R10 bank unchanged", d, model[i]);
        end

        // R4: transfer count, most-significant byte first
        addr_wr(8'd18); val_wr(8'hAB); val_wr(8'hCD); val_wr(8'hEF);
        model[18] = 8'hAB; model[19] = 8'hCD; model[20] = 8'hEF;
        chk("R4 count output", xfer_count, 24'hABCDEF);
        addr_wr(8'd18);
        for (int i = 18; i < 21; i++) begin
            val_rd(d); chk("R4 count readback", d, model[i]);
        end

        // R6: busy refuses ordinary registers without advancing
        eng_busy = 1'b1;
        addr_wr(8'd3);
        val_rd(d); chk("R6 refused read", d, 8'h00);
        val_wr(8'hAA);
        eng_busy = 1'b0;
        val_rd(d); chk("R6 no write no advance", d, model[3]);
        eng_busy = 1'b1;
        addr_wr(8'd24); val_wr(8'h31); model[24] = 8'h31;
        chk("R6 R8 command accepted while busy", cmd_start, 1'b1);
        chk("R8 command code", cmd_code, 8'h31);
        @(negedge clk); chk("R8 start is one cycle", cmd_start, 1'b0);
        val_wr(8'h77); model[25] = 8'h77;
        val_rd(d); chk("R6 data register open while busy", d, 8'h77);
        eng_busy = 1'b0;

        // R7: command in progress blocks the command register
        eng_busy = 1'b1; eng_cip = 1'b1;
        addr_wr(8'd24); val_wr(8'h42);
        chk("R7 no start when ignored", cmd_start, 1'b0);
        asr_rd(d); chk("R7 ignored flag", d, 8'h70);
        val_rd(d); chk("R7 command read refused", d, 8'h00);
        addr_wr(8'd25); val_wr(8'h99); model[25] = 8'h99;
        eng_busy = 1'b0; eng_cip = 1'b0;
        addr_wr(8'd24);
        val_rd(d); chk("R7 command unchanged", d, 8'h31);
        val_rd(d); chk("R7 data written during cip", d, 8'h99);
        addr_wr(8'd24); val_wr(8'h07);
        chk("R8 start after accept", cmd_start, 1'b1);
        chk("R8 code after accept", cmd_code, 8'h07);
        asr_rd(d); chk("R8 ignored flag cleared", d, 8'h00);

        // R9: interrupt set, read of status clears, set wins over clear
        @(negedge clk); eng_int_set = 1'b1; eng_status = 8'h16;
        @(negedge clk); eng_int_set = 1'b0;
        asr_rd(d); chk("R9 interrupt pending", d, 8'h80);
        addr_wr(8'd23);
        val_rd(d); chk("R9 status byte loaded", d, 8'h16);
        asr_rd(d); chk("R9 cleared by status read", d, 8'h00);
        addr_wr(8'd23);
        @(negedge clk);
        host_addr_sel = 1'b0; host_rd = 1'b1; eng_int_set = 1'b1; eng_status = 8'h5A;
        @(negedge clk);
        host_rd = 1'b0; eng_int_set = 1'b0;
        chk("R9 read returns prior status", host_rdata, 8'h16);
        asr_rd(d); chk("R9 set wins over clear", d, 8'h80);
        addr_wr(8'd23);
        val_rd(d); chk("R9 new status byte", d, 8'h5A);
        asr_rd(d); chk("R9 cleared again", d, 8'h00);

        // R11: reset in mid-operation clears everything
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        chk("R11 count cleared", xfer_count, 24'h0);
        chk("R11 code cleared", cmd_code, 8'h00);
        val_rd(d); chk("R11 index cleared", d, 8'h00);

        finish_run();
    end
endmodule